// File: doc/BRIEF.md
# External Fault Detector with Dual Dropout

This block tells a through fault apart from an internal fault in a line current differential scheme. On each sample strobe it takes the restraining and differential current magnitudes and compares each with the value it had exactly one power cycle earlier. When the restraint has jumped by more than 0.75 per-unit but the differential has grown by less than half as much, for 6 strobes in a row, the block declares an external fault. A second detection source, the other detection path, enters as a single input that triggers detection directly on a strobe.

Once declared, the detection is held by two counters that both count sample strobes. A minimum-hold counter keeps it for 3 power cycles and cannot be cancelled. A ride-through counter keeps it for 60 power cycles, long enough to cover fast reclosing, and a cancel pulse can clear it. Any new trigger reloads both counters, including after a cancel.

Top module: `ext_fault_detector`

## Requirements
- R1: A synchronous active-high reset drives `extFault`, `shortHold` and `longHold` low. It also clears the one-cycle history to zero, so the first 32 strobes after reset compare against zero.
- R2: The change-based path is armed only when the restraint magnitude minus its value 32 strobes earlier is strictly greater than 0.75 pu of `BASE`, which is 768 at the default `BASE` of 1024. A fall in magnitude counts as a change of zero.
- R3: The ratio test passes only when twice the differential change is strictly less than the restraint change. Twice the change equal to it fails.
- R4: The change-based trigger fires on the 6th consecutive strobe on which both R2 and R3 hold. A strobe that fails either test restarts the count. `extFault` is high right after the clock edge of that 6th strobe.
- R5: After the last trigger, `shortHold` stays high through 95 further strobes and goes low on the 96th.
- R6: After the last trigger, `longHold` goes low on the 1920th strobe if it is not cancelled. `extFault` is the OR of `shortHold` and `longHold`.
- R7: A `cancelLong` pulse clears `longHold` on the next edge. `shortHold` keeps counting, so `extFault` stays high until the minimum hold expires.
- R8: `altTrig` high on a strobe triggers detection. Every trigger reloads both counters, which sets `shortHold` and `longHold` high again even after a cancel.
- R9: Without a strobe, no counter, history entry or output changes. `altTrig`, `restrainMag` and `diffMag` are ignored then.
- R10: If a trigger and `cancelLong` occur on the same edge, the trigger wins and `longHold` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStb | input | 1 | One-cycle strobe marking a new sample |
| restrainMag | input | MAG_W | Unsigned restraining current magnitude |
| diffMag | input | MAG_W | Unsigned differential current magnitude |
| altTrig | input | 1 | Trigger from the other detection path, sampled on a strobe |
| cancelLong | input | 1 | Pulse that cancels the ride-through hold |
| extFault | output | 1 | External fault detected |
| shortHold | output | 1 | Minimum-hold counter is running |
| longHold | output | 1 | Ride-through counter is running |

## Verification
The bench aims at the strict comparisons: a restraint step of exactly 768, and a differential exactly half the restraint step, must not arm. A design that used greater-or-equal would trip on these. Five qualifying strobes followed by a failing one must not detect, which exposes a dwell counter that does not restart. A restraint step held for a full cycle must stop qualifying once the history catches up, with the minimum hold ending exactly 96 strobes after the last qualifying sample, which catches an off-by-one in the history depth or the hold length. Further tests cover a cancel that clears the short hold, a strobe-less period that moves a counter, a trigger that loses to a simultaneous cancel, and a reset that leaves stale history behind; each of these mistakes shows up as a wrong hold flag at the ports.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic advance;
  } xfdStrobe_t;

  // Qualification flags from datapath to control
  typedef struct packed {
    logic armed;
    logic ratioOk;
  } xfdFlags_t;
endpackage

// File: rtl/xfd_datapath.sv
module xfd_datapath
  import xfd_pkg::*;
#(
  parameter int SPC   = 32,
  parameter int MAG_W = 16,
  parameter int BASE  = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  xfdStrobe_t       stb,
  input  logic [MAG_W-1:0] restrainMag,
  input  logic [MAG_W-1:0] diffMag,
  output xfdFlags_t        flags
);
  localparam int PTR_W = (SPC > 1) ? $clog2(SPC) : 1;
  localparam logic [MAG_W-1:0] ARM_THR = MAG_W'((BASE >> 1) + (BASE >> 2));

  logic [MAG_W-1:0] rHist [SPC];
  logic [MAG_W-1:0] dHist [SPC];
  logic [PTR_W-1:0] wrPtr;

  logic [MAG_W:0]   rDelta, dDelta;
  logic [MAG_W-1:0] rRise, dRise;

  // Change against the entry written one power cycle ago
  always_comb begin
    rDelta = {1'b0, restrainMag} - {1'b0, rHist[wrPtr]};
    dDelta = {1'b0, diffMag} - {1'b0, dHist[wrPtr]};
    rRise  = rDelta[MAG_W] ? '0 : rDelta[MAG_W-1:0];
    dRise  = dDelta[MAG_W] ? '0 : dDelta[MAG_W-1:0];
    flags.armed   = rRise > ARM_THR;
    flags.ratioOk = {dRise, 1'b0} < {1'b0, rRise};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      for (int i = 0; i < SPC; i++) begin
        rHist[i] <= '0;
        dHist[i] <= '0;
      end
    end else if (stb.advance) begin
      rHist[wrPtr] <= restrainMag;
      dHist[wrPtr] <= diffMag;
      wrPtr <= (wrPtr == PTR_W'(SPC - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (stb.advance && wrPtr == PTR_W'(SPC - 1)) |=> (wrPtr == '0)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.advance |=> $stable(wrPtr)); // R9
endmodule

// File: rtl/xfd_control.sv
module xfd_control
  import xfd_pkg::*;
#(
  parameter int SPC       = 32,
  parameter int DWELL_NUM = 3,
  parameter int DWELL_DEN = 16,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleStb,
  input  logic       altTrig,
  input  logic       cancelLong,
  input  xfdFlags_t  flags,
  output xfdStrobe_t stb,
  output logic       extFault,
  output logic       shortHold,
  output logic       longHold
);
  localparam int DWELL   = (SPC * DWELL_NUM / DWELL_DEN > 0) ? SPC * DWELL_NUM / DWELL_DEN : 1;
  localparam int SHORT_N = SPC * SHORT_CYC;
  localparam int LONG_N  = SPC * LONG_CYC;
  localparam int DW_W    = $clog2(DWELL + 1);
  localparam int SH_W    = $clog2(SHORT_N + 1);
  localparam int LG_W    = $clog2(LONG_N + 1);

  logic [DW_W-1:0] dwellCnt;
  logic [SH_W-1:0] shortCnt;
  logic [LG_W-1:0] longCnt;
  logic            adv, qualify, acTrig, trig;

  assign adv     = sampleStb & ~rst;
  assign stb.advance = adv;
  assign qualify = flags.armed & flags.ratioOk;
  assign acTrig  = adv & qualify & (dwellCnt == DW_W'(DWELL - 1));
  assign trig    = acTrig | (adv & altTrig);

  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt <= '0;
      shortCnt <= '0;
      longCnt  <= '0;
    end else begin
      if (adv) begin
        if (!qualify) dwellCnt <= '0;
        else if (dwellCnt != DW_W'(DWELL - 1)) dwellCnt <= dwellCnt + 1'b1;
      end
      if (trig) shortCnt <= SH_W'(SHORT_N);
      else if (adv && shortCnt != '0) shortCnt <= shortCnt - 1'b1;
      if (trig) longCnt <= LG_W'(LONG_N);
      else if (cancelLong) longCnt <= '0;
      else if (adv && longCnt != '0) longCnt <= longCnt - 1'b1;
    end
  end

  assign shortHold = shortCnt != '0;
  assign longHold  = longCnt != '0;
  assign extFault  = shortHold | longHold;

  AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (rst)
    trig |=> (shortHold && longHold)); // R8
  AST_CANCEL_LONG: assert property (@(posedge clk) disable iff (rst)
    (cancelLong && !trig) |=> !longHold); // R7
  AST_CANCEL_KEEPS_SHORT: assert property (@(posedge clk) disable iff (rst)
    (cancelLong && !adv) |=> $stable(shortCnt)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(dwellCnt) && $stable(shortCnt))); // R9
  AST_TRIG_BEATS_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (trig && cancelLong) |=> longHold); // R10
endmodule

// File: rtl/ext_fault_detector.sv
module ext_fault_detector
  import xfd_pkg::*;
#(
  parameter int SPC       = 32,
  parameter int MAG_W     = 16,
  parameter int BASE      = 1024,
  parameter int DWELL_NUM = 3,
  parameter int DWELL_DEN = 16,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleStb,
  input  logic [MAG_W-1:0] restrainMag,
  input  logic [MAG_W-1:0] diffMag,
  input  logic             altTrig,
  input  logic             cancelLong,
  output logic             extFault,
  output logic             shortHold,
  output logic             longHold
);
  xfdStrobe_t stb;
  xfdFlags_t  flags;

  xfd_datapath #(.SPC(SPC), .MAG_W(MAG_W), .BASE(BASE)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .restrainMag(restrainMag), .diffMag(diffMag), .flags(flags)
  );

  xfd_control #(
    .SPC(SPC), .DWELL_NUM(DWELL_NUM), .DWELL_DEN(DWELL_DEN),
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .altTrig(altTrig),
    .cancelLong(cancelLong), .flags(flags), .stb(stb),
    .extFault(extFault), .shortHold(shortHold), .longHold(longHold)
  );

  AST_OUT_LOW_IN_RESET: assert property (@(posedge clk)
    rst |=> !extFault); // R1
endmodule

// File: tb/ext_fault_detector_tb.sv
`timescale 1ns/1ps
module ext_fault_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleStb = 1'b0;
  logic [15:0] restrainMag = '0;
  logic [15:0] diffMag = '0;
  logic altTrig = 1'b0;
  logic cancelLong = 1'b0;
  logic extFault, shortHold, longHold;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_fault_detector u_dut (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .restrainMag(restrainMag),
    .diffMag(diffMag), .altTrig(altTrig), .cancelLong(cancelLong),
    .extFault(extFault), .shortHold(shortHold), .longHold(longHold)
  );

  // {restraint, differential, expected extFault}; history is zero, so the
  // changes equal the inputs. Covers R2 (768 not armed, 769 armed),
  // R3 (d*2 == r fails) and R4 (five then break, six detects).
  localparam logic [32:0] VEC [19] = '{
    {16'd768, 16'd0, 1'b0}, {16'd768, 16'd0, 1'b0}, {16'd768, 16'd0, 1'b0},
    {16'd768, 16'd0, 1'b0}, {16'd768, 16'd0, 1'b0}, {16'd768, 16'd0, 1'b0},
    {16'd2000, 16'd999, 1'b0}, {16'd2000, 16'd999, 1'b0}, {16'd2000, 16'd999, 1'b0},
    {16'd2000, 16'd999, 1'b0}, {16'd2000, 16'd999, 1'b0}, {16'd2000, 16'd1000, 1'b0},
    {16'd769, 16'd0, 1'b0}, {16'd769, 16'd0, 1'b0}, {16'd769, 16'd0, 1'b0},
    {16'd769, 16'd0, 1'b0}, {16'd769, 16'd0, 1'b0}, {16'd769, 16'd0, 1'b1},
    {16'd0, 16'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1; sampleStb = 1'b0; altTrig = 1'b0; cancelLong = 1'b0;
    restrainMag = '0; diffMag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sample(input logic [15:0] r, input logic [15:0] d, input logic a);
    @(negedge clk);
    restrainMag = r; diffMag = d; altTrig = a; sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0; altTrig = 1'b0;
  endtask

  task automatic cancelPulse();
    @(negedge clk); cancelLong = 1'b1;
    @(negedge clk); cancelLong = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 extFault in reset", extFault, 1'b0);
    chk("R1 longHold in reset", longHold, 1'b0);
    resetDut();
    chk("R1 shortHold after reset", shortHold, 1'b0);

    // Vector table: R2, R3, R4
    for (int i = 0; i < 19; i++) begin
      sample(VEC[i][32:17], VEC[i][16:1], 1'b0);
      chk($sformatf("R4 vector %0d", i), extFault, VEC[i][0]);
    end

    // R5, R6, R8, R9: alternate trigger and full hold timing
    resetDut();
    sample(16'd0, 16'd0, 1'b1);
    chk("R8 alt trigger shortHold", shortHold, 1'b1);
    chk("R8 alt trigger longHold", longHold, 1'b1);
    repeat (95) sample(16'd0, 16'd0, 1'b0);
    chk("R5 shortHold after 95", shortHold, 1'b1);
    @(negedge clk); altTrig = 1'b1; restrainMag = 16'd5000;
    repeat (20) @(negedge clk);
    altTrig = 1'b0; restrainMag = '0;
    chk("R9 idle keeps shortHold", shortHold, 1'b1);
    sample(16'd0, 16'd0, 1'b0);
    chk("R5 shortHold after 96", shortHold, 1'b0);
    chk("R6 longHold after 96", longHold, 1'b1);
    chk("R6 extFault after 96", extFault, 1'b1);
    repeat (1823) sample(16'd0, 16'd0, 1'b0);
    chk("R6 longHold after 1919", longHold, 1'b1);
    sample(16'd0, 16'd0, 1'b0);
    chk("R6 longHold after 1920", longHold, 1'b0);
    chk("R6 extFault after 1920", extFault, 1'b0);

    // R7, R8: cancel then retrigger
    resetDut();
    sample(16'd0, 16'd0, 1'b1);
    repeat (10) sample(16'd0, 16'd0, 1'b0);
    cancelPulse();
    chk("R7 cancel clears longHold", longHold, 1'b0);
    chk("R7 cancel keeps shortHold", shortHold, 1'b1);
    repeat (85) sample(16'd0, 16'd0, 1'b0);
    chk("R7 extFault after 95", extFault, 1'b1);
    sample(16'd0, 16'd0, 1'b0);
    chk("R7 extFault after 96", extFault, 1'b0);
    sample(16'd0, 16'd0, 1'b1);
    chk("R8 retrigger longHold", longHold, 1'b1);
    chk("R8 retrigger shortHold", shortHold, 1'b1);
    repeat (96) sample(16'd0, 16'd0, 1'b0);
    chk("R8 retrigger longHold past short", longHold, 1'b1);
    chk("R8 retrigger shortHold expired", shortHold, 1'b0);

    // R10: trigger and cancel on one edge
    resetDut();
    @(negedge clk);
    altTrig = 1'b1; sampleStb = 1'b1; cancelLong = 1'b1;
    @(negedge clk);
    altTrig = 1'b0; sampleStb = 1'b0; cancelLong = 1'b0;
    chk("R10 trigger beats cancel", longHold, 1'b1);

    // R2, R4, R5: held step against one-cycle history
    resetDut();
    for (int i = 0; i < 128; i++) begin
      sample(16'd2000, 16'd0, 1'b0);
      if (i == 4)   chk("R4 step five samples", extFault, 1'b0);
      if (i == 5)   chk("R4 step six samples", extFault, 1'b1);
      if (i == 126) chk("R2 history shortHold 126", shortHold, 1'b1);
      if (i == 127) chk("R2 history shortHold 127", shortHold, 1'b0);
    end

    // R1: reset clears history so the same level qualifies again
    resetDut();
    repeat (6) sample(16'd2000, 16'd0, 1'b0);
    chk("R1 history cleared by reset", extFault, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule